// File: doc/BRIEF.md
# Power-On Reset Sequencing Controller

This block produces the single internal reset of a small microcontroller. It merges four reset causes: a supply-good flag from an analog comparator, a watchdog time-out pulse, an active-low external reset pin, and a wake request that ends stop mode. Every cause except the bypassed wake path starts a one-shot delay timer. The timer counts edges of a separate slow RC clock, so the supply and the main crystal oscillator have time to settle before code runs.

A configuration bit selects how a stop-mode wake is handled. It can start the delay timer. It can also skip the timer, and in that case the wake line must stay asserted for a few main clocks before it is accepted. The external pin passes through a longer glitch filter. A status flag tells a power-up apart from a warm restart: the flag is cleared only by loss of supply, and it is set by a watchdog time-out or an accepted external reset.

Every register is cleared asynchronously while the supply flag is low. The reset output therefore asserts at once, and it is released only on a main clock edge. The slow clock, the external pin and the wake line each pass through a synchronizer chain before they are used. The slow clock's rising edges are detected in the main clock domain.

Top module: `por_seq_ctrl`

## Requirements
- R1: While `supply_ok` is 0, `chip_rst_n` is 0 and `warm_start` is 0. Both are forced asynchronously, without waiting for a clock edge.
- R2: When `supply_ok` returns to 1 (cold start), `chip_rst_n` stays 0 until `DELAY_TICKS` rising edges of `slow_clk` have been seen after the supply synchronizer settles. It then goes to 1 on a `clk` edge.
- R3: A one-cycle `wdt_timeout` pulse drives `chip_rst_n` to 0 on the next `clk` edge, starts the delay timer and sets `warm_start` to 1.
- R4: `ext_rst_n` is active low. A low level shorter than `EXT_FILTER` consecutive synchronized samples has no effect on `chip_rst_n` or `warm_start`.
- R5: An `ext_rst_n` low level held for `EXT_FILTER` consecutive synchronized samples asserts reset, starts the delay timer once and sets `warm_start` to 1.
- R6: With `stop_via_timer` = 1, a rising edge of the active-high `stop_wake` asserts reset and starts the delay timer.
- R7: With `stop_via_timer` = 0, `stop_wake` must stay high for `WAKE_QUAL` consecutive synchronized samples. Reset is then held until `stop_wake` drops, and the timer is not used. A shorter pulse has no effect.
- R8: A new trigger that arrives while the timer is running restarts the count from zero, which lengthens the reset.
- R9: A stop-mode wake never changes `warm_start`, and `warm_start` never falls while the supply is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main (crystal) clock |
| slow_clk | input | 1 | Free-running RC clock for the delay timer, asynchronous to clk |
| supply_ok | input | 1 | Supply comparator flag, 1 = supply good; acts as the asynchronous clear |
| wdt_timeout | input | 1 | Watchdog time-out pulse, synchronous to clk |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| stop_wake | input | 1 | Stop-mode wake request, active high, asynchronous |
| stop_via_timer | input | 1 | 1 = wake goes through the delay timer, 0 = qualified bypass |
| chip_rst_n | output | 1 | Internal chip reset, active low |
| warm_start | output | 1 | 0 = last reset was a power-up, 1 = warm restart occurred |

## Verification
The timer-restart case (R8) is the hardest to reach from the ports. A second trigger must land while the slow-clock count is partway through. Once the first reset is released, the restart can no longer be told apart from a fresh start. The bench fires a watchdog pulse, waits about half of the delay window, fires another, and checks that reset is still held after the first window would have ended. A behavioural model that tracks sample histories and run lengths of every input gives the exact release cycle, both for this case and for the filter and qualification boundaries.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } tmr_state_e;

   // counter width able to hold values 0..max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/por_sync.sv
module por_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("por_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/por_qualify.sv
module por_qualify #(
   parameter int LEN = 5
) (
   input  logic clk,
   input  logic arst_n,
   input  logic lvl,
   output logic fire,
   output logic full
);
   import por_seq_pkg::*;

   if (LEN < 2) begin : g_bad_len
      $error("por_qualify: LEN must be at least 2");
   end

   localparam int CW = cnt_width(LEN);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)    run_cnt <= '0;
      else if (!lvl)  run_cnt <= '0;
      else if (!full) run_cnt <= run_cnt + 1'b1;
   end

   assign full = (run_cnt == CW'(LEN));
   assign fire = lvl && (run_cnt == CW'(LEN - 1));

   // R4/R7: a qualified event needs the level already present one cycle earlier
   a_r4_fire_needs_run: assert property (@(posedge clk) disable iff (!arst_n)
      fire |-> $past(lvl));
endmodule

// File: rtl/por_delay.sv
module por_delay #(
   parameter int TICKS = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic run_en,
   input  logic tick,
   input  logic trig,
   output logic busy
);
   import por_seq_pkg::*;

   if (TICKS < 1) begin : g_bad_ticks
      $error("por_delay: TICKS must be at least 1");
   end

   localparam int TW = cnt_width(TICKS - 1);

   tmr_state_e    state;
   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state <= TMR_RUN;
         tcnt  <= '0;
      end else if (trig) begin
         state <= TMR_RUN;
         tcnt  <= '0;
      end else if (state == TMR_RUN && run_en && tick) begin
         if (tcnt == TW'(TICKS - 1)) state <= TMR_IDLE;
         else                        tcnt  <= tcnt + 1'b1;
      end
   end

   assign busy = (state == TMR_RUN);

   // R2: the timer only expires on a slow-clock edge with the supply settled
   a_r2_expire_on_tick: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(busy) |-> ($past(tick) && $past(run_en)));
endmodule

// File: rtl/por_seq_ctrl.sv
module por_seq_ctrl #(
   parameter int DELAY_TICKS = 16,
   parameter int EXT_FILTER  = 18,
   parameter int WAKE_QUAL   = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic slow_clk,
   input  logic supply_ok,
   input  logic wdt_timeout,
   input  logic ext_rst_n,
   input  logic stop_wake,
   input  logic stop_via_timer,
   output logic chip_rst_n,
   output logic warm_start
);
   if (EXT_FILTER <= WAKE_QUAL) begin : g_bad_filter
      $error("por_seq_ctrl: EXT_FILTER is expected to exceed WAKE_QUAL");
   end

   logic por_ok, ext_s, wake_s, slow_s;
   logic wake_d, slow_d;
   logic ext_fire, ext_full_unused;
   logic wake_fire_unused, wake_full;
   logic wake_rise, slow_tick, byp_hold, trig, busy;
   logic rst_q, warm_q;

   // supply-good release synchronizer
   por_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_por (
      .clk(clk), .arst_n(supply_ok), .din(1'b1), .dout(por_ok));

   por_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ext (
      .clk(clk), .arst_n(supply_ok), .din(ext_rst_n), .dout(ext_s));

   por_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wake (
      .clk(clk), .arst_n(supply_ok), .din(stop_wake), .dout(wake_s));

   por_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_slow (
      .clk(clk), .arst_n(supply_ok), .din(slow_clk), .dout(slow_s));

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok) begin
         wake_d <= 1'b0;
         slow_d <= 1'b0;
      end else begin
         wake_d <= wake_s;
         slow_d <= slow_s;
      end
   end

   assign wake_rise = wake_s & ~wake_d;
   assign slow_tick = slow_s & ~slow_d;

   por_qualify #(.LEN(EXT_FILTER)) u_ext_filt (
      .clk(clk), .arst_n(supply_ok), .lvl(~ext_s),
      .fire(ext_fire), .full(ext_full_unused));

   por_qualify #(.LEN(WAKE_QUAL)) u_wake_qual (
      .clk(clk), .arst_n(supply_ok), .lvl(wake_s),
      .fire(wake_fire_unused), .full(wake_full));

   assign byp_hold = ~stop_via_timer & wake_full;
   assign trig     = wdt_timeout | ext_fire | (stop_via_timer & wake_rise);

   por_delay #(.TICKS(DELAY_TICKS)) u_delay (
      .clk(clk), .arst_n(supply_ok), .run_en(por_ok), .tick(slow_tick),
      .trig(trig), .busy(busy));

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok) begin
         rst_q  <= 1'b0;
         warm_q <= 1'b0;
      end else begin
         rst_q <= ~(busy | trig | byp_hold);
         if (wdt_timeout | ext_fire) warm_q <= 1'b1;
      end
   end

   assign chip_rst_n = rst_q;
   assign warm_start = warm_q;

   // R1: supply loss always holds the chip in reset
   a_r1_supply_low_resets: assert property (@(posedge clk)
      !supply_ok |-> !chip_rst_n);

   // R3: a watchdog pulse reaches the reset output one edge later
   a_r3_wdt_asserts_reset: assert property (@(posedge clk) disable iff (!supply_ok)
      wdt_timeout |=> !chip_rst_n);

   // R7: a qualified bypass wake keeps reset asserted
   a_r7_bypass_holds_reset: assert property (@(posedge clk) disable iff (!supply_ok)
      byp_hold |=> !chip_rst_n);

   // R9: the warm flag is only cleared by supply loss
   a_r9_warm_never_falls: assert property (@(posedge clk) disable iff (!supply_ok)
      !$fell(warm_start));
endmodule

// File: tb/por_seq_ctrl_tb_top.sv
module por_seq_ctrl_tb_top;
   localparam int DELAY = 16;
   localparam int FILT  = 18;
   localparam int QUAL  = 5;

   logic clk = 1'b0;
   logic slow_clk = 1'b0;
   logic supply_ok = 1'b1;
   logic wdt_timeout = 1'b0;
   logic ext_rst_n = 1'b1;
   logic stop_wake = 1'b0;
   logic stop_via_timer = 1'b0;
   logic chip_rst_n, warm_start;

   int checks = 0;
   int failures = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   int sc = 0;
   always @(negedge clk) begin
      sc++;
      if (sc == 4) begin
         sc = 0;
         slow_clk = ~slow_clk;
      end
   end

   por_seq_ctrl #(.DELAY_TICKS(DELAY), .EXT_FILTER(FILT), .WAKE_QUAL(QUAL),
                  .SYNC_STAGES(2)) dut_i (
      .clk(clk), .slow_clk(slow_clk), .supply_ok(supply_ok),
      .wdt_timeout(wdt_timeout), .ext_rst_n(ext_rst_n), .stop_wake(stop_wake),
      .stop_via_timer(stop_via_timer), .chip_rst_n(chip_rst_n),
      .warm_start(warm_start));

   // behavioural reference: input sample histories and run lengths
   bit he[4], hw[4], hs[4];
   int re[4], rw[4];
   int pw = 0;
   int m_cnt = 0;
   bit m_busy = 1'b1, m_rst_n = 1'b0, m_warm = 1'b0;

   initial begin
      for (int k = 0; k < 4; k++) begin
         he[k] = 1'b1; hw[k] = 1'b0; hs[k] = 1'b0; re[k] = 0; rw[k] = 0;
      end
   end

   always @(posedge clk) begin
      bit trig, byp, tick, ext_ok;
      if (!supply_ok) begin
         for (int k = 0; k < 4; k++) begin
            he[k] = 1'b1; hw[k] = 1'b0; hs[k] = 1'b0; re[k] = 0; rw[k] = 0;
         end
         pw = 0; m_busy = 1'b1; m_cnt = 0; m_rst_n = 1'b0; m_warm = 1'b0;
      end else begin
         for (int k = 3; k > 0; k--) begin
            he[k] = he[k-1]; hw[k] = hw[k-1]; hs[k] = hs[k-1];
            re[k] = re[k-1]; rw[k] = rw[k-1];
         end
         he[0] = ext_rst_n; hw[0] = stop_wake; hs[0] = slow_clk;
         re[0] = ext_rst_n ? 0 : re[1] + 1;
         rw[0] = stop_wake ? rw[1] + 1 : 0;
         ext_ok = (re[2] == FILT);
         trig = wdt_timeout || ext_ok || (stop_via_timer && hw[2] && !hw[3]);
         byp  = !stop_via_timer && (rw[3] >= QUAL);
         tick = hs[2] && !hs[3];
         m_rst_n = !(m_busy || trig || byp);
         if (trig) begin
            m_busy = 1'b1; m_cnt = 0;
         end else if (m_busy && pw >= 2 && tick) begin
            if (m_cnt == DELAY - 1) m_busy = 1'b0;
            else m_cnt++;
         end
         if (wdt_timeout || ext_ok) m_warm = 1'b1;
         pw++;
      end
   end

   task automatic check(input string req, input string what, input logic act,
                        input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // one cycle: compare against the model at the falling edge
   task automatic step();
      @(negedge clk);
      check(phase, "chip_rst_n vs model", chip_rst_n, m_rst_n);
      check(phase, "warm_start vs model", warm_start, m_warm);
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   bit done = 1'b0;
   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1 supply_ok = 1'b0;
      // R1: reset state
      phase = "R1";
      cycles(3);
      check("R1", "reset chip_rst_n", chip_rst_n, 1'b0);
      check("R1", "reset warm_start", warm_start, 1'b0);
      supply_ok = 1'b1;
      // R2: cold start delay
      phase = "R2";
      cycles(60);
      check("R2", "held during delay", chip_rst_n, 1'b0);
      cycles(140);
      check("R2", "released after delay", chip_rst_n, 1'b1);
      // R6: wake through timer
      phase = "R6";
      stop_via_timer = 1'b1;
      stop_wake = 1'b1;
      cycles(3);
      stop_wake = 1'b0;
      cycles(20);
      check("R6", "wake starts timer", chip_rst_n, 1'b0);
      cycles(180);
      check("R6", "released after wake delay", chip_rst_n, 1'b1);
      check("R9", "wake leaves warm at 0", warm_start, 1'b0);
      // R7: qualified bypass
      phase = "R7";
      stop_via_timer = 1'b0;
      cycles(2);
      stop_wake = 1'b1;
      cycles(QUAL - 2);
      stop_wake = 1'b0;
      cycles(10);
      check("R7", "short wake ignored", chip_rst_n, 1'b1);
      stop_wake = 1'b1;
      cycles(12);
      check("R7", "held wake asserts reset", chip_rst_n, 1'b0);
      stop_wake = 1'b0;
      cycles(10);
      check("R7", "bypass released", chip_rst_n, 1'b1);
      check("R9", "bypass leaves warm at 0", warm_start, 1'b0);
      // R4: short external pulse
      phase = "R4";
      ext_rst_n = 1'b0;
      cycles(FILT - 2);
      ext_rst_n = 1'b1;
      cycles(10);
      check("R4", "short ext ignored rst", chip_rst_n, 1'b1);
      check("R4", "short ext ignored warm", warm_start, 1'b0);
      // R5: accepted external reset
      phase = "R5";
      ext_rst_n = 1'b0;
      cycles(FILT + 6);
      check("R5", "ext accepted rst", chip_rst_n, 1'b0);
      check("R5", "ext sets warm", warm_start, 1'b1);
      ext_rst_n = 1'b1;
      cycles(200);
      check("R5", "ext released", chip_rst_n, 1'b1);
      // R1: asynchronous assertion on supply loss
      phase = "R1";
      supply_ok = 1'b0;
      #1;
      check("R1", "async chip_rst_n", chip_rst_n, 1'b0);
      check("R1", "async warm clear", warm_start, 1'b0);
      cycles(4);
      supply_ok = 1'b1;
      phase = "R2";
      cycles(200);
      check("R2", "second cold start released", chip_rst_n, 1'b1);
      // R3: watchdog
      phase = "R3";
      wdt_timeout = 1'b1;
      step();
      wdt_timeout = 1'b0;
      check("R3", "wdt asserts reset", chip_rst_n, 1'b0);
      check("R3", "wdt sets warm", warm_start, 1'b1);
      cycles(200);
      check("R3", "wdt released", chip_rst_n, 1'b1);
      // R8: retrigger while running
      phase = "R8";
      wdt_timeout = 1'b1;
      step();
      wdt_timeout = 1'b0;
      cycles(80);
      wdt_timeout = 1'b1;
      step();
      wdt_timeout = 1'b0;
      cycles(100);
      check("R8", "restart extends reset", chip_rst_n, 1'b0);
      cycles(100);
      check("R8", "released after restart", chip_rst_n, 1'b1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule